// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a fully associative address translation buffer. A single array of entries serves both instruction fetch and data access. Each entry covers two adjacent virtual pages, one even and one odd, under one shared tag. The entry holds an address-space identifier, a global flag and its own page-size code, and a separate physical mapping for each of the two pages. Page sizes run from 4 KB to 16 MB in steps of four.

A lookup is purely combinational, so the physical address is ready in the same cycle as the cache access and can feed the physical-tag compare directly. All entries are compared at once. Each entry ignores the low page-number bits that its size covers. The virtual address bit just above the page offset then selects the even or the odd mapping. The outcome is hit, miss or invalid, with a modify fault for stores to pages that are not writable.

Entries are loaded through an indexed write port and brought back through an indexed read port. A probe searches the array for a page-pair tag and reports the matching index. If more than one entry matches a lookup or a probe, a sticky error flag is raised.

Top module: `tlb_paired`

## Requirements
- R1: After reset, the following outputs are low: lk_hit, lk_miss, lk_inval, lk_modfault, rd_vld, pr_done and multi_hit.
- R2: An entry whose tag matches the lookup returns lk_hit in the same cycle if the selected half is valid. It also returns lk_pa, built from that half's frame number above the offset and the virtual address bits within the offset, and lk_cattr from that half. A half is encoded as {pfn[23:0], cattr[2:0], dirty, valid}, with valid at bit 0.
- R3: Virtual address bit 12+2*size selects the mapping: a 0 selects the even half (wr_lo) and a 1 selects the odd half (wr_hi).
- R4: Size code s (0..6) gives pages of 4 KB*4^s. The low 2*s bits of the 19-bit page-pair tag (virtual address bits 31:13) are excluded from the compare. A written code of 7 is stored as 6.
- R5: An entry matches only if its global flag is set or its identifier equals cur_asid.
- R6: If no entry matches, lk_miss is raised. If an entry matches but the selected half has its valid bit clear, lk_inval is raised. In both cases lk_pa is zero.
- R7: A hit with lk_store high on a half whose dirty bit is clear raises lk_modfault.
- R8: rd_en returns the entry at rd_idx on the rd_* outputs one cycle later, with rd_vld high for that one cycle. The size is returned as stored.
- R9: pr_en searches for pr_vpn2 under cur_asid. One cycle later it raises pr_done, together with either the matching index or pr_nf.
- R10: When several entries match, the lowest index is used. If a lookup or probe with two or more matches is active at a clock edge, multi_hit is set and stays set until reset.
- R11: While lk_vld is low, lk_hit, lk_miss, lk_inval, lk_modfault, lk_pa and lk_cattr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_asid | input | 8 | Current address-space identifier |
| lk_vld | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_store | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | Valid translation found |
| lk_miss | output | 1 | No entry matched |
| lk_inval | output | 1 | Matching half invalid |
| lk_modfault | output | 1 | Store to non-writable half |
| lk_pa | output | 36 | Physical address |
| lk_cattr | output | 3 | Cache attribute of the hit |
| wr_en | input | 1 | Indexed write strobe |
| wr_idx | input | 6 | Write index |
| wr_vpn2 | input | 19 | Page-pair tag to write |
| wr_size | input | 3 | Page-size code to write |
| wr_asid | input | 8 | Identifier to write |
| wr_glob | input | 1 | Global flag to write |
| wr_lo | input | 29 | Even half mapping |
| wr_hi | input | 29 | Odd half mapping |
| rd_en | input | 1 | Indexed read strobe |
| rd_idx | input | 6 | Read index |
| rd_vld | output | 1 | Read data valid |
| rd_vpn2 | output | 19 | Read tag |
| rd_size | output | 3 | Read size code |
| rd_asid | output | 8 | Read identifier |
| rd_glob | output | 1 | Read global flag |
| rd_lo | output | 29 | Read even half |
| rd_hi | output | 29 | Read odd half |
| pr_en | input | 1 | Probe strobe |
| pr_vpn2 | input | 19 | Probe tag |
| pr_done | output | 1 | Probe result valid |
| pr_idx | output | 6 | Probe matching index |
| pr_nf | output | 1 | Probe found nothing |
| multi_hit | output | 1 | Sticky multiple-match flag |

## Verification
Lookup outcomes, the physical address and the fault flag are combinational, so they are due in the same cycle the request is presented. The bench drives each request on a falling edge and samples one nanosecond later. Read data and probe results pass through one register and are due at the next rising edge. The bench samples them at the falling edge that follows. The multiple-match flag updates on the rising edge that sees the offending request, so a behavioural model advances on each rising edge and is compared on every falling edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W     = 32;
  parameter int PA_W     = 36;
  parameter int ASID_W   = 8;
  parameter int SIZE_W   = 3;
  parameter int MAX_SIZE = 6;
  parameter int OFF_MIN  = 12;

  localparam int VPN2_W = VA_W - OFF_MIN - 1;
  localparam int PFN_W  = PA_W - OFF_MIN;
  localparam int HALF_W = PFN_W + 5;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [2:0]       cattr;
    logic             dirty;
    logic             valid;
  } half_t;

  typedef struct packed {
    logic [VPN2_W-1:0] vpn2;
    logic [SIZE_W-1:0] size;
    logic [ASID_W-1:0] asid;
    logic              glob;
    half_t             lo;
    half_t             hi;
  } entry_t;

  // Bits of the page-pair tag that a page of this size leaves out of the compare
  function automatic logic [VPN2_W-1:0] vpn_mask(input logic [SIZE_W-1:0] sz);
    logic [VPN2_W-1:0] m;
    for (int i = 0; i < VPN2_W; i++) m[i] = (i < 2 * int'(sz));
    return m;
  endfunction

  function automatic logic [SIZE_W-1:0] clamp_size(input logic [SIZE_W-1:0] sz);
    return (int'(sz) > MAX_SIZE) ? SIZE_W'(MAX_SIZE) : sz;
  endfunction
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match
  import tlb_pkg::*;
(
  input  logic [VPN2_W-1:0] ent_vpn2,
  input  logic [SIZE_W-1:0] ent_size,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic              ent_glob,
  input  logic [VPN2_W-1:0] key_lk,
  input  logic [VPN2_W-1:0] key_pr,
  input  logic [ASID_W-1:0] asid,
  output logic              hit_lk,
  output logic              hit_pr
);
  logic [VPN2_W-1:0] care;
  logic              asid_ok;

  always_comb begin
    care    = ~vpn_mask(ent_size);
    asid_ok = ent_glob | (ent_asid == asid);
    hit_lk  = asid_ok && (((ent_vpn2 ^ key_lk) & care) == '0);
    hit_pr  = asid_ok && (((ent_vpn2 ^ key_pr) & care) == '0);
  end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int N     = 48,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any,
  output logic             multi
);
  always_comb begin
    idx   = '0;
    any   = 1'b0;
    multi = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) begin
        if (any) multi = 1'b1;
        any = 1'b1;
      end
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_pa_form.sv
module tlb_pa_form
  import tlb_pkg::*;
(
  input  logic [VA_W-1:0]   va,
  input  logic [SIZE_W-1:0] size,
  input  half_t             lo,
  input  half_t             hi,
  output logic [PA_W-1:0]   pa,
  output logic [2:0]        cattr,
  output logic              valid,
  output logic              dirty
);
  int              sel_pos;
  logic            odd;
  half_t           half;
  logic [PA_W-1:0] off_m;

  always_comb begin
    sel_pos = OFF_MIN + 2 * int'(size);
    odd     = va[sel_pos];
    half    = odd ? hi : lo;
    for (int i = 0; i < PA_W; i++) off_m[i] = (i < sel_pos);
    pa      = ({half.pfn, {OFF_MIN{1'b0}}} & ~off_m) | (PA_W'(va) & off_m);
    cattr   = half.cattr;
    valid   = half.valid;
    dirty   = half.dirty;
  end
endmodule

// File: rtl/tlb_paired.sv
module tlb_paired
  import tlb_pkg::*;
#(
  parameter  int N_ENT = 48,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              lk_vld,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              lk_store,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_inval,
  output logic              lk_modfault,
  output logic [PA_W-1:0]   lk_pa,
  output logic [2:0]        lk_cattr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic [HALF_W-1:0] wr_lo,
  input  logic [HALF_W-1:0] wr_hi,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [VPN2_W-1:0] rd_vpn2,
  output logic [SIZE_W-1:0] rd_size,
  output logic [ASID_W-1:0] rd_asid,
  output logic              rd_glob,
  output logic [HALF_W-1:0] rd_lo,
  output logic [HALF_W-1:0] rd_hi,
  input  logic              pr_en,
  input  logic [VPN2_W-1:0] pr_vpn2,
  output logic              pr_done,
  output logic [IDX_W-1:0]  pr_idx,
  output logic              pr_nf,
  output logic              multi_hit
);
  entry_t ent_q [N_ENT];
  entry_t ent_d [N_ENT];
  entry_t wr_ent;

  logic [N_ENT-1:0]  m_lk, m_pr;
  logic [IDX_W-1:0]  lk_idx, pr_sel;
  logic              lk_any, lk_multi, pr_any, pr_multi;
  logic [VPN2_W-1:0] lk_key;

  entry_t            sel_ent;
  logic [PA_W-1:0]   f_pa;
  logic [2:0]        f_cattr;
  logic              f_valid, f_dirty;

  entry_t            rd_q, rd_d;
  logic              rd_vld_q, rd_vld_d;
  logic              pr_done_q, pr_done_d, pr_nf_q, pr_nf_d;
  logic [IDX_W-1:0]  pr_idx_q, pr_idx_d;
  logic              mh_q, mh_d;

  assign lk_key = lk_va[VA_W-1:OFF_MIN+1];

  // Parallel tag compare, one comparator pair per entry
  for (genvar g = 0; g < N_ENT; g++) begin : g_cam
    tlb_cam_match u_match (
      .ent_vpn2 (ent_q[g].vpn2),
      .ent_size (ent_q[g].size),
      .ent_asid (ent_q[g].asid),
      .ent_glob (ent_q[g].glob),
      .key_lk   (lk_key),
      .key_pr   (pr_vpn2),
      .asid     (cur_asid),
      .hit_lk   (m_lk[g]),
      .hit_pr   (m_pr[g])
    );
  end

  tlb_first_hit #(.N(N_ENT), .IDX_W(IDX_W)) u_lk_enc (
    .vec (m_lk), .idx (lk_idx), .any (lk_any), .multi (lk_multi)
  );

  tlb_first_hit #(.N(N_ENT), .IDX_W(IDX_W)) u_pr_enc (
    .vec (m_pr), .idx (pr_sel), .any (pr_any), .multi (pr_multi)
  );

  assign sel_ent = ent_q[lk_idx];

  tlb_pa_form u_pa (
    .va    (lk_va),
    .size  (sel_ent.size),
    .lo    (sel_ent.lo),
    .hi    (sel_ent.hi),
    .pa    (f_pa),
    .cattr (f_cattr),
    .valid (f_valid),
    .dirty (f_dirty)
  );

  // Lookup outcome
  always_comb begin
    lk_hit      = lk_vld & lk_any & f_valid;
    lk_inval    = lk_vld & lk_any & ~f_valid;
    lk_miss     = lk_vld & ~lk_any;
    lk_modfault = lk_hit & lk_store & ~f_dirty;
    lk_pa       = lk_hit ? f_pa : '0;
    lk_cattr    = lk_hit ? f_cattr : '0;
  end

  // Entry storage next state
  always_comb begin
    wr_ent.vpn2 = wr_vpn2;
    wr_ent.size = clamp_size(wr_size);
    wr_ent.asid = wr_asid;
    wr_ent.glob = wr_glob;
    wr_ent.lo   = half_t'(wr_lo);
    wr_ent.hi   = half_t'(wr_hi);
    for (int e = 0; e < N_ENT; e++) begin
      ent_d[e] = ent_q[e];
      if (wr_en && (wr_idx == IDX_W'(e))) ent_d[e] = wr_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++) ent_q[e] <= '0;
    end else if (wr_en) begin
      for (int e = 0; e < N_ENT; e++) ent_q[e] <= ent_d[e];
    end
  end

  // Read, probe and sticky flag next state
  always_comb begin
    rd_vld_d  = rd_en;
    rd_d      = rd_q;
    if (rd_en) rd_d = (int'(rd_idx) < N_ENT) ? ent_q[rd_idx] : '0;
    pr_done_d = pr_en;
    pr_idx_d  = pr_idx_q;
    pr_nf_d   = pr_nf_q;
    if (pr_en) begin
      pr_idx_d = pr_any ? pr_sel : '0;
      pr_nf_d  = ~pr_any;
    end
    mh_d = mh_q | (lk_vld & lk_multi) | (pr_en & pr_multi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= '0;
      rd_vld_q  <= 1'b0;
      pr_done_q <= 1'b0;
      pr_idx_q  <= '0;
      pr_nf_q   <= 1'b0;
      mh_q      <= 1'b0;
    end else begin
      rd_vld_q  <= rd_vld_d;
      pr_done_q <= pr_done_d;
      mh_q      <= mh_d;
      if (rd_en) rd_q <= rd_d;
      if (pr_en) begin
        pr_idx_q <= pr_idx_d;
        pr_nf_q  <= pr_nf_d;
      end
    end
  end

  assign rd_vld    = rd_vld_q;
  assign rd_vpn2   = rd_q.vpn2;
  assign rd_size   = rd_q.size;
  assign rd_asid   = rd_q.asid;
  assign rd_glob   = rd_q.glob;
  assign rd_lo     = rd_q.lo;
  assign rd_hi     = rd_q.hi;
  assign pr_done   = pr_done_q;
  assign pr_idx    = pr_idx_q;
  assign pr_nf     = pr_nf_q;
  assign multi_hit = mh_q;
endmodule

// File: rtl/tlb_paired_chk.sv
module tlb_paired_chk #(
  parameter int N_ENT = 48,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_vld,
  input logic             lk_store,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_inval,
  input logic             lk_modfault,
  input logic             rd_en,
  input logic             rd_vld,
  input logic             pr_en,
  input logic             pr_done,
  input logic             pr_nf,
  input logic [IDX_W-1:0] pr_idx,
  input logic             multi_hit
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    lk_vld |-> $countones({lk_hit, lk_miss, lk_inval}) == 1); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_vld |-> !(lk_hit || lk_miss || lk_inval || lk_modfault)); // R11
  AST_MODF_ON_STORE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_modfault |-> (lk_hit && lk_store)); // R7
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld); // R8
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_vld); // R8
  AST_PROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    pr_en |=> pr_done); // R9
  AST_PROBE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_done && !pr_nf) |-> (int'(pr_idx) < N_ENT)); // R9
  AST_MH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit |=> multi_hit); // R10
endmodule

bind tlb_paired tlb_paired_chk #(.N_ENT(N_ENT), .IDX_W(IDX_W)) chk_i (
  .clk (clk), .rst_n (rst_n), .lk_vld (lk_vld), .lk_store (lk_store),
  .lk_hit (lk_hit), .lk_miss (lk_miss), .lk_inval (lk_inval),
  .lk_modfault (lk_modfault), .rd_en (rd_en), .rd_vld (rd_vld),
  .pr_en (pr_en), .pr_done (pr_done), .pr_nf (pr_nf), .pr_idx (pr_idx),
  .multi_hit (multi_hit)
);

// File: tb/tlb_paired_tb_top.sv
module tlb_paired_tb_top;
  localparam int N = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cur_asid = '0;
  logic        lk_vld = 1'b0, lk_store = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_hit, lk_miss, lk_inval, lk_modfault;
  logic [35:0] lk_pa;
  logic [2:0]  lk_cattr;
  logic        wr_en = 1'b0, wr_glob = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [18:0] wr_vpn2 = '0;
  logic [2:0]  wr_size = '0;
  logic [7:0]  wr_asid = '0;
  logic [28:0] wr_lo = '0, wr_hi = '0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_idx = '0;
  logic        rd_vld, rd_glob;
  logic [18:0] rd_vpn2;
  logic [2:0]  rd_size;
  logic [7:0]  rd_asid;
  logic [28:0] rd_lo, rd_hi;
  logic        pr_en = 1'b0;
  logic [18:0] pr_vpn2 = '0;
  logic        pr_done, pr_nf, multi_hit;
  logic [5:0]  pr_idx;

  int n_tests = 0, n_fail = 0;

  // Behavioural model of the array
  logic [18:0] m_vpn2 [N];
  logic [2:0]  m_size [N];
  logic [7:0]  m_asid [N];
  logic        m_glob [N];
  logic [28:0] m_lo [N], m_hi [N];
  logic        m_mh = 1'b0;

  tlb_paired dut_i (.*);

  always #2.5 clk = ~clk;

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int m_find(input logic [18:0] key, input logic [7:0] asid, output int cnt);
    int first = -1;
    cnt = 0;
    for (int e = 0; e < N; e++) begin
      logic [18:0] care = ~((19'd1 << (2 * m_size[e])) - 19'd1);
      if ((m_glob[e] || m_asid[e] == asid) && (((m_vpn2[e] ^ key) & care) == 0)) begin
        cnt++;
        if (first < 0) first = e;
      end
    end
    return first;
  endfunction

  // Sticky multiple-match model, advanced on every rising edge
  always @(posedge clk) begin
    int c1, c2, d;
    if (!rst_n) m_mh <= 1'b0;
    else begin
      c1 = 0; c2 = 0;
      if (lk_vld) d = m_find(lk_va[31:13], cur_asid, c1);
      if (pr_en)  d = m_find(pr_vpn2, cur_asid, c2);
      if (c1 > 1 || c2 > 1) m_mh <= 1'b1;
    end
  end

  always @(negedge clk) if (rst_n) chk("R10 multi_hit per cycle", multi_hit, m_mh);

  function automatic logic [28:0] mk_half(input logic [23:0] pfn, input logic [2:0] c,
                                          input logic d, input logic v);
    return {pfn, c, d, v};
  endfunction

  task automatic do_write(input int idx, input logic [18:0] vpn2, input logic [2:0] sz,
                          input logic [7:0] asid, input logic g,
                          input logic [28:0] lo, input logic [28:0] hi);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_vpn2 = vpn2; wr_size = sz;
    wr_asid = asid; wr_glob = g; wr_lo = lo; wr_hi = hi;
    @(negedge clk);
    wr_en = 1'b0;
    m_vpn2[idx] = vpn2; m_size[idx] = (sz > 3'd6) ? 3'd6 : sz;
    m_asid[idx] = asid; m_glob[idx] = g; m_lo[idx] = lo; m_hi[idx] = hi;
  endtask

  task automatic do_lookup(input string req, input logic [31:0] va, input logic st,
                           input logic [7:0] asid);
    int cnt, e, pos;
    logic [28:0] h;
    logic eh, ei, em, ef;
    logic [35:0] epa;
    logic [2:0] ec;
    lk_vld = 1'b1; lk_va = va; lk_store = st; cur_asid = asid;
    #1;
    e = m_find(va[31:13], asid, cnt);
    eh = 0; ei = 0; em = 0; ef = 0; epa = 0; ec = 0;
    if (e < 0) em = 1;
    else begin
      pos = 12 + 2 * m_size[e];
      h = va[pos] ? m_hi[e] : m_lo[e];
      if (!h[0]) ei = 1;
      else begin
        eh = 1;
        ef = st && !h[1];
        epa = (({h[28:5], 12'h000} >> pos) << pos) | ({4'h0, va} & ((36'd1 << pos) - 36'd1));
        ec = h[4:2];
      end
    end
    chk({req, " hit"}, lk_hit, eh);
    chk({req, " miss"}, lk_miss, em);
    chk({req, " inval"}, lk_inval, ei);
    chk({req, " modfault"}, lk_modfault, ef);
    chk({req, " pa"}, lk_pa, epa);
    chk({req, " cattr"}, lk_cattr, ec);
    @(negedge clk);
    lk_vld = 1'b0; lk_store = 1'b0;
  endtask

  task automatic do_read(input int idx);
    rd_en = 1'b1; rd_idx = 6'(idx);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R8 rd_vld", rd_vld, 1);
    chk("R8 rd_vpn2", rd_vpn2, m_vpn2[idx]);
    chk("R8 rd_size", rd_size, m_size[idx]);
    chk("R8 rd_asid", rd_asid, m_asid[idx]);
    chk("R8 rd_glob", rd_glob, m_glob[idx]);
    chk("R8 rd_lo", rd_lo, m_lo[idx]);
    chk("R8 rd_hi", rd_hi, m_hi[idx]);
    @(negedge clk);
    chk("R8 rd_vld single pulse", rd_vld, 0);
  endtask

  task automatic do_probe(input logic [18:0] key, input logic [7:0] asid);
    int cnt, e;
    pr_en = 1'b1; pr_vpn2 = key; cur_asid = asid;
    @(negedge clk);
    pr_en = 1'b0;
    e = m_find(key, asid, cnt);
    chk("R9 pr_done", pr_done, 1);
    chk("R9 pr_nf", pr_nf, (e < 0));
    if (e >= 0) chk("R9 pr_idx", pr_idx, e);
  endtask

  initial begin
    for (int e = 0; e < N; e++) begin
      m_vpn2[e] = 0; m_size[e] = 0; m_asid[e] = 0; m_glob[e] = 0; m_lo[e] = 0; m_hi[e] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 lk_hit", lk_hit, 0);
    chk("R1 lk_miss", lk_miss, 0);
    chk("R1 lk_inval", lk_inval, 0);
    chk("R1 lk_modfault", lk_modfault, 0);
    chk("R1 rd_vld", rd_vld, 0);
    chk("R1 pr_done", pr_done, 0);
    chk("R1 multi_hit", multi_hit, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_write(3, 19'h00010, 3'd0, 8'd5, 1'b0,
             mk_half(24'h000ABC, 3'd3, 1'b1, 1'b1), mk_half(24'h000123, 3'd2, 1'b0, 1'b1));
    do_lookup("R2 even hit", 32'h0002_0345, 1'b0, 8'd5);
    do_lookup("R3 odd half", 32'h0002_1ABC, 1'b0, 8'd5);
    do_lookup("R7 store to clean half", 32'h0002_1ABC, 1'b1, 8'd5);
    do_lookup("R7 store to dirty half", 32'h0002_0004, 1'b1, 8'd5);
    do_lookup("R5 asid mismatch", 32'h0002_0345, 1'b0, 8'd6);

    do_write(7, 19'h00200, 3'd0, 8'd1, 1'b1,
             mk_half(24'h055555, 3'd1, 1'b1, 1'b1), mk_half(24'h0AAAAA, 3'd4, 1'b1, 1'b1));
    do_lookup("R5 global any asid", 32'h0040_1FFF, 1'b0, 8'd9);

    do_write(10, 19'h01000, 3'd2, 8'd5, 1'b0,
             mk_half(24'h012340, 3'd5, 1'b1, 1'b1), mk_half(24'h056780, 3'd6, 1'b1, 1'b1));
    do_lookup("R4 64K masked bits even", 32'h0200_A123, 1'b0, 8'd5);
    do_lookup("R3 64K odd select bit16", 32'h0201_F456, 1'b0, 8'd5);

    do_write(11, 19'h40000, 3'd7, 8'd5, 1'b0,
             mk_half(24'hC00000, 3'd7, 1'b1, 1'b1), mk_half(24'hD00000, 3'd0, 1'b1, 1'b1));
    do_read(11);
    do_lookup("R4 16M even", 32'h80AB_CDEF, 1'b0, 8'd5);
    do_lookup("R4 16M odd", 32'h81AB_CDEF, 1'b0, 8'd5);

    do_write(12, 19'h02000, 3'd0, 8'd5, 1'b0,
             mk_half(24'h000777, 3'd1, 1'b1, 1'b0), mk_half(24'h000888, 3'd1, 1'b1, 1'b1));
    do_lookup("R6 invalid half", 32'h0400_0010, 1'b1, 8'd5);
    do_lookup("R6 miss", 32'h0E00_0000, 1'b0, 8'd5);

    do_read(3);
    do_probe(19'h00010, 8'd5);
    do_probe(19'h07000, 8'd5);
    do_probe(19'h01003, 8'd5);

    // R11: lookup disabled with a matching address on the bus
    lk_vld = 1'b0; lk_va = 32'h0002_0345; lk_store = 1'b1; cur_asid = 8'd5;
    #1;
    chk("R11 idle hit", lk_hit, 0);
    chk("R11 idle miss", lk_miss, 0);
    chk("R11 idle pa", lk_pa, 0);
    chk("R11 idle cattr", lk_cattr, 0);
    chk("R11 idle modfault", lk_modfault, 0);
    @(negedge clk);

    // R10: duplicate tag, lowest index wins, flag becomes sticky
    do_write(20, 19'h00010, 3'd0, 8'd5, 1'b0,
             mk_half(24'h0FFFFF, 3'd7, 1'b1, 1'b1), mk_half(24'h0EEEEE, 3'd7, 1'b1, 1'b1));
    chk("R10 flag before duplicate lookup", multi_hit, 0);
    do_lookup("R10 lowest index wins", 32'h0002_0345, 1'b0, 8'd5);
    chk("R10 flag set", multi_hit, 1);
    do_lookup("R10 unrelated lookup", 32'h0040_0000, 1'b0, 8'd5);
    repeat (2) @(negedge clk);
    chk("R10 flag sticky", multi_hit, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule